// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Arbiter

This block sits at the issue stage of an in-order core that has two ALU pipes. Each cycle it looks at two candidate instructions, the older and the younger, each given as a class code. It decides how many of them issue (zero, one or two) and which pipe each issued instruction takes. Register dependencies and forwarding are not considered here; only the structural resources are: the two pipes, one load/store issue slot and one branch issue slot.

Instructions that split into several micro-ops hold resources on cycles after they issue. A two-micro-op load/store or multiply occupies both pipes on its first cycle and pipe 0 on its second cycle, and the load/store form also keeps the load/store slot. A three-micro-op multiply occupies both pipes on its first two cycles and pipe 0 on its third. The block records these pending holds in a short reservation register and keeps new instructions off the held resources. On the first cycle of any multi-micro-op instruction nothing pairs with it. On the middle cycle of a three-micro-op multiply nothing issues at all.

Top module: `dual_issue_arb`

## Requirements
- R1: An asynchronous active-low reset clears every pending reservation. After reset `held_mask` is 0 and both pipes are free.
- R2: Class codes are 0 ALU, 1 load/store one micro-op, 2 load/store two micro-ops, 3 multiply one micro-op, 4 multiply two micro-ops, 5 multiply three micro-ops, 6 branch and 7 call. ALU, one-micro-op load/store and branch each need one pipe of either kind. A pipe mask has bit 0 for pipe 0 and bit 1 for pipe 1. Such an older instruction takes pipe 0 when that pipe is free and pipe 1 otherwise.
- R3: At most one load/store (class 1 or 2) and at most one branch-slot user (class 6 or 7) issue in a cycle. This also holds against a load/store slot that an earlier instruction still keeps.
- R4: A two-micro-op load/store issues alone with pipe mask 2'b11. On the next cycle pipe 0 and the load/store slot are held (`held_mask` = 2'b01), while pipe 1 and the branch slot stay usable.
- R5: A two-micro-op multiply issues alone with pipe mask 2'b11, even beside a call. On the next cycle pipe 0 is held.
- R6: A three-micro-op multiply issues alone with mask 2'b11. On the next cycle both pipes are held and nothing issues. On the cycle after that only pipe 0 is held and two instructions may issue.
- R7: A one-micro-op multiply uses pipe 0 only. When the younger candidate is such a multiply and pipe 1 is free, a flexible older instruction takes pipe 1.
- R8: A call uses only the branch slot. It is reported with pipe mask 2'b00 and may issue while both pipes are busy with other work, but not on a cycle where a multi-micro-op instruction locks out issue.
- R9: Issue is in order. The younger issues only when the older issues in the same cycle. `old_stall` is high exactly when the older is valid and does not issue.
- R10: A younger instruction takes a pipe that is neither held nor taken by the older. No pipe is ever given twice in a cycle. Pipe masks of instructions that do not issue are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| old_vld | input | 1 | Older candidate present |
| old_cls | input | 3 | Older candidate class code |
| yng_vld | input | 1 | Younger candidate present |
| yng_cls | input | 3 | Younger candidate class code |
| issue_cnt | output | 2 | Instructions issued this cycle (0 to 2) |
| old_pipe | output | 2 | Pipes taken by the older's first micro-op |
| yng_pipe | output | 2 | Pipes taken by the younger |
| held_mask | output | 2 | Pipes held this cycle by earlier multi-micro-op instructions |
| old_stall | output | 1 | Older candidate valid but held back |

## Verification
Directed pairs cover each class as the older candidate against flexible, pipe-0-only, slot-sharing and call partners. These show whether a rejection comes from pipe exhaustion, the load/store or branch slot, or the multi-micro-op lockout. Follow-up cycles after each multi-micro-op class separate the lock cycle from the pipe-0-only tail, and they separate a two-cycle hold from a three-cycle hold. A long pseudo-random stream of class pairs, with either candidate sometimes invalid, then runs back-to-back holds and a reset asserted in the middle of a hold.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int CLS_W      = 3;
  localparam int NPIPE      = 2;
  localparam int RESV_DEPTH = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU  = 3'd0,
    CLS_LS1  = 3'd1,
    CLS_LS2  = 3'd2,
    CLS_MUL1 = 3'd3,
    CLS_MUL2 = 3'd4,
    CLS_MUL3 = 3'd5,
    CLS_BR   = 3'd6,
    CLS_CALL = 3'd7
  } cls_e;

  // one cycle of held resources
  typedef struct packed {
    logic lock;  // no issue at all this cycle
    logic p1;
    logic p0;
    logic ls;
  } resv_t;

  // resource demand of one candidate
  typedef struct packed {
    logic  solo;   // first micro-op of a multi-micro-op class
    logic  both;   // needs both pipes
    logic  pin0;   // needs pipe 0 only
    logic  anyp;   // needs one pipe, either one
    logic  ls;     // load/store slot
    logic  br;     // branch slot
    resv_t fut1;   // holds on the next cycle
    resv_t fut2;   // holds two cycles later
  } need_t;

endpackage

// File: rtl/iss_need_dec.sv
module iss_need_dec
  import arb_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output need_t            need
);

  always_comb begin
    need = '0;
    unique case (cls_e'(cls))
      CLS_ALU:  need.anyp = 1'b1;
      CLS_LS1: begin
        need.anyp = 1'b1;
        need.ls   = 1'b1;
      end
      CLS_LS2: begin
        need.both    = 1'b1;
        need.solo    = 1'b1;
        need.ls      = 1'b1;
        need.fut1.p0 = 1'b1;
        need.fut1.ls = 1'b1;
      end
      CLS_MUL1: need.pin0 = 1'b1;
      CLS_MUL2: begin
        need.both    = 1'b1;
        need.solo    = 1'b1;
        need.fut1.p0 = 1'b1;
      end
      CLS_MUL3: begin
        need.both      = 1'b1;
        need.solo      = 1'b1;
        need.fut1.lock = 1'b1;
        need.fut1.p0   = 1'b1;
        need.fut1.p1   = 1'b1;
        need.fut2.p0   = 1'b1;
      end
      CLS_BR: begin
        need.anyp = 1'b1;
        need.br   = 1'b1;
      end
      CLS_CALL: need.br = 1'b1;
      default:  need = '0;
    endcase
  end

endmodule

// File: rtl/iss_resv_trk.sv
module iss_resv_trk
  import arb_pkg::*;
#(
  parameter int DEPTH = RESV_DEPTH
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  resv_t [DEPTH-1:0]       fut,   // fut[0] is the next cycle
  output resv_t                   cur
);

  resv_t [DEPTH-1:0] st_q;
  resv_t [DEPTH-1:0] st_d;
  resv_t [DEPTH-1:0] shin;
  logic              st_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == DEPTH-1) begin : g_last
      assign shin[i] = '0;
    end else begin : g_mid
      assign shin[i] = st_q[i+1];
    end
    assign st_d[i] = shin[i] | (load ? fut[i] : resv_t'('0));
  end

  // idle when nothing is pending and nothing new arrives
  assign st_en = load | (|st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign cur = st_q[0];

  AST_LOCK_HAS_PIPES: assert property (@(posedge clk) disable iff (!rst_n)
    cur.lock |-> (cur.p0 && cur.p1)); // R6

endmodule

// File: rtl/iss_pick.sv
module iss_pick
  import arb_pkg::*;
(
  input  resv_t             held,
  input  logic              o_v,
  input  need_t             n_o,
  input  logic              y_v,
  input  need_t             n_y,
  output logic              o_iss,
  output logic              y_iss,
  output logic [NPIPE-1:0]  o_pm,
  output logic [NPIPE-1:0]  y_pm
);

  logic p0f, p1f, lsf;
  logic o_room, o_side;
  logic [NPIPE-1:0] o_raw, y_raw;
  logic r0, r1, lsr, brr, y_room;

  always_comb begin
    p0f = ~held.p0 & ~held.lock;
    p1f = ~held.p1 & ~held.lock;
    lsf = ~held.ls;

    // older candidate
    if (n_o.both)      o_room = p0f & p1f;
    else if (n_o.pin0) o_room = p0f;
    else if (n_o.anyp) o_room = p0f | p1f;
    else               o_room = ~held.lock;
    o_iss = o_v & o_room & (~n_o.ls | lsf);

    // step aside to pipe 1 for a younger pipe-0-only multiply
    o_side = y_v & n_y.pin0 & p1f;
    if (n_o.both)      o_raw = 2'b11;
    else if (n_o.pin0) o_raw = 2'b01;
    else if (n_o.anyp) o_raw = (p0f & ~o_side) ? 2'b01 : 2'b10;
    else               o_raw = 2'b00;
    o_pm = o_iss ? o_raw : 2'b00;

    // what is left for the younger
    r0  = p0f & ~o_pm[0];
    r1  = p1f & ~o_pm[1];
    lsr = lsf & ~(o_iss & n_o.ls);
    brr = ~(o_iss & n_o.br);

    if (n_y.both)      y_room = r0 & r1;
    else if (n_y.pin0) y_room = r0;
    else if (n_y.anyp) y_room = r0 | r1;
    else               y_room = 1'b1;
    y_iss = o_iss & ~n_o.solo & ~n_y.solo & y_v & y_room
          & (~n_y.ls | lsr) & (~n_y.br | brr);

    if (n_y.both)      y_raw = 2'b11;
    else if (n_y.pin0) y_raw = 2'b01;
    else if (n_y.anyp) y_raw = r0 ? 2'b01 : 2'b10;
    else               y_raw = 2'b00;
    y_pm = y_iss ? y_raw : 2'b00;
  end

endmodule

// File: rtl/dual_issue_arb.sv
module dual_issue_arb
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             old_vld,
  input  logic [2:0]       old_cls,
  input  logic             yng_vld,
  input  logic [2:0]       yng_cls,
  output logic [1:0]       issue_cnt,
  output logic [1:0]       old_pipe,
  output logic [1:0]       yng_pipe,
  output logic [1:0]       held_mask,
  output logic             old_stall
);

  localparam int NSLOT = 2;

  logic  [CLS_W-1:0] cls_in [NSLOT];
  need_t             need   [NSLOT];
  resv_t             held;
  resv_t [RESV_DEPTH-1:0] fut;
  logic              o_iss, y_iss;

  assign cls_in[0] = old_cls;
  assign cls_in[1] = yng_cls;

  for (genvar s = 0; s < NSLOT; s++) begin : g_dec
    iss_need_dec u_dec (
      .cls  (cls_in[s]),
      .need (need[s])
    );
  end

  iss_pick u_pick (
    .held  (held),
    .o_v   (old_vld),
    .n_o   (need[0]),
    .y_v   (yng_vld),
    .n_y   (need[1]),
    .o_iss (o_iss),
    .y_iss (y_iss),
    .o_pm  (old_pipe),
    .y_pm  (yng_pipe)
  );

  assign fut[0] = need[0].fut1;
  assign fut[1] = need[0].fut2;

  iss_resv_trk #(.DEPTH(RESV_DEPTH)) u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (o_iss),
    .fut   (fut),
    .cur   (held)
  );

  assign issue_cnt = {1'b0, o_iss} + {1'b0, y_iss};
  assign held_mask = {held.p1, held.p0};
  assign old_stall = old_vld & ~o_iss;

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    old_stall |-> (issue_cnt == 2'd0)); // R9
  AST_PIPE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    ((old_pipe & yng_pipe) == 2'b00) && (((old_pipe | yng_pipe) & held_mask) == 2'b00)); // R10
  AST_SOLO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (old_vld && !old_stall && (old_cls == 3'd2 || old_cls == 3'd4 || old_cls == 3'd5))
      |-> (issue_cnt == 2'd1 && old_pipe == 2'b11)); // R4
  AST_MUL2_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (old_vld && !old_stall && old_cls == 3'd4) |=> (held_mask == 2'b01)); // R5
  AST_MUL3_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (old_vld && !old_stall && old_cls == 3'd5) |=> (issue_cnt == 2'd0 && held_mask == 2'b11)); // R6
  AST_CALL_NOPIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (old_vld && !old_stall && old_cls == 3'd7) |-> (old_pipe == 2'b00)); // R8
  AST_MUL1_PIPE0: assert property (@(posedge clk) disable iff (!rst_n)
    (old_vld && !old_stall && old_cls == 3'd3) |-> (old_pipe == 2'b01)); // R7

endmodule

// File: tb/sim_dual_issue_arb.sv
module sim_dual_issue_arb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       old_vld, yng_vld;
  logic [2:0] old_cls, yng_cls;
  logic [1:0] issue_cnt, old_pipe, yng_pipe, held_mask;
  logic       old_stall;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  // reference state: holds per future cycle, index 0 = this cycle
  bit m_p0 [3];
  bit m_p1 [3];
  bit m_ls [3];
  bit m_lk [3];

  always #2 clk = ~clk;  // 250 MHz

  dual_issue_arb u0 (
    .clk(clk), .rst_n(rst_n),
    .old_vld(old_vld), .old_cls(old_cls),
    .yng_vld(yng_vld), .yng_cls(yng_cls),
    .issue_cnt(issue_cnt), .old_pipe(old_pipe), .yng_pipe(yng_pipe),
    .held_mask(held_mask), .old_stall(old_stall)
  );

  // 0 none, 1 either pipe, 2 pipe 0 only, 3 both pipes
  function automatic int pkind(int c);
    case (c)
      0, 1, 6: return 1;
      3:       return 2;
      2, 4, 5: return 3;
      default: return 0;
    endcase
  endfunction
  function automatic bit is_ls(int c);    return (c == 1 || c == 2); endfunction
  function automatic bit is_br(int c);    return (c == 6 || c == 7); endfunction
  function automatic bit is_multi(int c); return (c == 2 || c == 4 || c == 5); endfunction

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin
      m_p0[i] = 0; m_p1[i] = 0; m_ls[i] = 0; m_lk[i] = 0;
    end
  endtask

  task automatic step(input bit ov, input int oc, input bit yv, input int yc, input string tag);
    bit f0, f1, fl, oi, yi, side, ok;
    bit g0, g1, gl, gb;
    int ek, ecnt;
    logic [1:0] eop, eyp, ehm;
    bit est;
    @(negedge clk);
    old_vld = ov; old_cls = 3'(oc); yng_vld = yv; yng_cls = 3'(yc);
    #1;
    f0 = !m_p0[0] && !m_lk[0];
    f1 = !m_p1[0] && !m_lk[0];
    fl = !m_ls[0];
    ek = pkind(oc);
    case (ek)
      3: ok = f0 && f1;
      2: ok = f0;
      1: ok = f0 || f1;
      default: ok = !m_lk[0];
    endcase
    oi = ov && ok && (!is_ls(oc) || fl);
    side = yv && pkind(yc) == 2 && f1;
    eop = 2'b00;
    if (oi) begin
      case (ek)
        3: eop = 2'b11;
        2: eop = 2'b01;
        1: eop = (f0 && !side) ? 2'b01 : 2'b10;
        default: eop = 2'b00;
      endcase
    end
    g0 = f0 && !eop[0];
    g1 = f1 && !eop[1];
    gl = fl && !(oi && is_ls(oc));
    gb = !(oi && is_br(oc));
    case (pkind(yc))
      3: ok = g0 && g1;
      2: ok = g0;
      1: ok = g0 || g1;
      default: ok = 1;
    endcase
    yi = oi && yv && !is_multi(oc) && !is_multi(yc) && ok
         && (!is_ls(yc) || gl) && (!is_br(yc) || gb);
    eyp = 2'b00;
    if (yi) begin
      case (pkind(yc))
        2: eyp = 2'b01;
        1: eyp = g0 ? 2'b01 : 2'b10;
        default: eyp = 2'b00;
      endcase
    end
    ecnt = int'(oi) + int'(yi);
    ehm = {m_p1[0], m_p0[0]};
    est = ov && !oi;
    nvec++;
    if (issue_cnt !== 2'(ecnt) || old_pipe !== eop || yng_pipe !== eyp ||
        held_mask !== ehm || old_stall !== est) begin
      nfail++;
      $display("FAIL %s: cnt/op/yp/held/stall got %0d/%b/%b/%b/%b exp %0d/%b/%b/%b/%b",
               tag, issue_cnt, old_pipe, yng_pipe, held_mask, old_stall,
               ecnt, eop, eyp, ehm, est);
    end
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      m_p0[i] = m_p0[i+1]; m_p1[i] = m_p1[i+1]; m_ls[i] = m_ls[i+1]; m_lk[i] = m_lk[i+1];
    end
    m_p0[2] = 0; m_p1[2] = 0; m_ls[2] = 0; m_lk[2] = 0;
    if (oi) begin
      if (oc == 2) begin m_p0[0] = 1; m_ls[0] = 1; end
      if (oc == 4) m_p0[0] = 1;
      if (oc == 5) begin m_p0[0] = 1; m_p1[0] = 1; m_lk[0] = 1; m_p0[1] = 1; end
    end
  endtask

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0;
    old_vld = 0; yng_vld = 0; old_cls = 0; yng_cls = 0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    step(1, 0, 1, 0, "R1 reset state, two ALU");
    step(1, 4, 0, 0, "R1 MUL2 after reset");
    step(1, 0, 0, 0, "R2 ALU with pipe0 held");
    step(1, 1, 1, 6, "R2 LS1+BR");
    step(1, 1, 1, 1, "R3 two loads");
    step(1, 6, 1, 7, "R3 BR+CALL");
    step(1, 7, 1, 6, "R8 CALL+BR");
    step(1, 2, 1, 0, "R4 LS2 alone");
    step(1, 1, 1, 0, "R4 LS slot held");
    step(1, 0, 1, 0, "R4 hold released");
    step(1, 2, 1, 7, "R4 LS2+CALL");
    step(1, 0, 1, 7, "R4 tail pairs ALU+CALL");
    step(1, 4, 1, 7, "R5 MUL2 excludes CALL");
    step(1, 0, 1, 0, "R5 pipe0 held");
    step(1, 5, 1, 0, "R6 MUL3 alone");
    step(1, 7, 1, 0, "R6 lock cycle");
    step(1, 0, 1, 7, "R6 third cycle pairs");
    step(1, 0, 1, 3, "R7 ALU steps aside");
    step(1, 3, 1, 3, "R7 two MUL1");
    step(1, 7, 1, 0, "R8 CALL+ALU");
    step(1, 7, 1, 7, "R8 two CALL");
    step(0, 0, 1, 0, "R9 older absent");
    step(1, 5, 0, 0, "R9 MUL3 for stall");
    step(1, 0, 1, 0, "R9 stalled older");
    step(1, 1, 1, 3, "R10 younger takes leftover");

    // reset in the middle of a hold
    step(1, 5, 0, 0, "R1 MUL3 before reset");
    @(negedge clk);
    rst_n = 1'b0; old_vld = 0; yng_vld = 0;
    model_clear();
    #1;
    nvec++;
    if (held_mask !== 2'b00) begin
      nfail++;
      $display("FAIL R1 held after reset got %b exp 00", held_mask);
    end
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 1, 0, "R1 free after reset");

    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[1], int'(lf[4:2]), lf[5] | lf[6], int'(lf[9:7]), "R9 R10 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule